// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses the direction of conditional branches for a fetch unit. Two component predictors are read in the same cycle. The first is a per-address table of 2-bit saturating counters, selected by low bits of the fetch PC. The second is a table of 2-bit counters selected by a global history register that records recent branch directions. A third table of 2-bit chooser counters, also selected by global history, decides which of the two answers is passed out. The chooser learns, entry by entry, which component has been right more often.

The fetch side raises a predict strobe with a PC. In the same cycle it receives the direction and the history value that was used for the lookup. The history is then advanced speculatively with the predicted bit. When the branch resolves, the back end returns the PC, the real outcome, the direction that had been predicted and the saved history value. All three tables are trained from these. If the prediction was wrong, the history is rebuilt from the saved value with the real outcome appended.

Top module: `bp_tournament`

## Requirements
- R1: After reset every counter in all three tables holds 1 and the history is zero. The first prediction is therefore not-taken, and `pred_ghr` reads 0.
- R2: The per-address table is selected by `pred_pc[LOC_IDX_W+1:2]` (bits 11:2 by default). PCs that differ only outside those bits share an entry. A counter value of 2 or 3 means taken.
- R3: The history table and the chooser are both selected by the current history value. A chooser value of 2 or 3 passes out the history-table answer; 0 or 1 passes out the per-address answer.
- R4: On every resolve, the per-address entry (selected by `res_pc`) and the history-table entry (selected by `res_ghr`) move one step toward the outcome. They saturate at 0 and at 3.
- R5: On a resolve, the chooser entry selected by `res_ghr` changes only if the two components' directions disagree before the update. It then moves one step toward the component that matched the outcome (up for the history table, down for the per-address table), saturating at 0 and 3.
- R6: A predict strobe that does not coincide with a mispredicted resolve shifts the history left by one. The predicted direction enters at bit 0 and the top bit is dropped.
- R7: A resolve whose `res_pred` differs from `res_taken` loads the history with `{res_ghr[GHR_W-2:0], res_taken}`. This takes priority over a predict in the same cycle.
- R8: A prediction made in the same cycle as a resolve reads the table contents from before that resolve's update.
- R9: Table contents change only on resolves. The history holds whenever there is neither a predict nor a mispredicted resolve, so `pred_taken` depends on `pred_pc` alone between such events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronized to clk on release |
| pred_valid | input | 1 | Predict strobe; advances the history |
| pred_pc | input | PC_W | Fetch PC to predict |
| pred_taken | output | 1 | Predicted direction, combinational from the current state |
| pred_ghr | output | GHR_W | History value used for this lookup (snapshot for later resolve) |
| res_valid | input | 1 | Resolve strobe; trains the tables |
| res_pc | input | PC_W | PC of the resolving branch |
| res_taken | input | 1 | Actual outcome |
| res_pred | input | 1 | Direction that was predicted for this branch |
| res_ghr | input | GHR_W | History snapshot returned from prediction time |

## Verification
The hardest state to reach from the ports is a chooser entry that prefers the history table while the per-address entry for the probed PC disagrees with it. Only then does the choice itself show at `pred_taken`. The stimulus builds this state in steps. First, a resolve under a fixed history snapshot trains the history-table entry. Next, a resolve from a second PC makes the two components disagree, which moves the chooser. A deliberate mispredict then loads the history register with that same snapshot. Finally, a third, untrained PC is probed, so its per-address answer contradicts the history table.

// File: rtl/bp_tour_pkg.sv
package bp_tour_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_NT = 2'd1;

  // one saturating step toward the given direction
  function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
    ctr2_t r;
    if (up) r = (c == 2'd3) ? c : c + 2'd1;
    else    r = (c == 2'd0) ? c : c - 2'd1;
    return r;
  endfunction

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_tour_pkg::*;
#(
  parameter int    IDX_W   = 10,
  parameter ctr2_t RST_VAL = CTR_WEAK_NT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output ctr2_t            rd_a_val,
  input  logic [IDX_W-1:0] rd_b_idx,
  output ctr2_t            rd_b_val,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ctr2_t            wr_val
);

  localparam int DEPTH = 1 << IDX_W;

  ctr2_t mem_q [DEPTH];

  // reads see the stored value before any write in this cycle
  assign rd_a_val = mem_q[rd_a_idx];
  assign rd_b_val = mem_q[rd_b_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_VAL;
    end else if (wr_en) begin
      mem_q[wr_idx] <= wr_val;
    end
  end

endmodule

// File: rtl/bp_hist_reg.sv
module bp_hist_reg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         shift_bit,
  output logic [W-1:0] hist
);

  logic [W-1:0] hist_d;
  logic [W-1:0] hist_q;

  // repair load outranks the speculative shift
  always_comb begin
    hist_d = hist_q;
    if (load_en)       hist_d = load_val;
    else if (shift_en) hist_d = {hist_q[W-2:0], shift_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign hist = hist_q;

endmodule

// File: rtl/bp_tournament.sv
module bp_tournament
  import bp_tour_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int LOC_IDX_W = 10,
  parameter int GHR_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pred_valid,
  input  logic [PC_W-1:0]  pred_pc,
  output logic             pred_taken,
  output logic [GHR_W-1:0] pred_ghr,
  input  logic             res_valid,
  input  logic [PC_W-1:0]  res_pc,
  input  logic             res_taken,
  input  logic             res_pred,
  input  logic [GHR_W-1:0] res_ghr
);

  localparam int LOC_LO = 2;
  localparam int LOC_HI = LOC_IDX_W + LOC_LO - 1;

  logic [LOC_IDX_W-1:0] loc_idx_p, loc_idx_r;
  logic [GHR_W-1:0]     ghr_q;
  ctr2_t loc_p, loc_r, glb_p, glb_r, cho_p, cho_r;
  ctr2_t loc_w, glb_w, cho_w;
  logic  loc_dir_r, glb_dir_r, cho_we, mispred, shift_en;

  assign loc_idx_p = pred_pc[LOC_HI:LOC_LO];
  assign loc_idx_r = res_pc[LOC_HI:LOC_LO];

  // per-address counters
  bp_ctr_table #(.IDX_W(LOC_IDX_W), .RST_VAL(CTR_WEAK_NT)) u_loc (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(loc_idx_p), .rd_a_val(loc_p),
    .rd_b_idx(loc_idx_r), .rd_b_val(loc_r),
    .wr_en(res_valid), .wr_idx(loc_idx_r), .wr_val(loc_w)
  );

  // history-pattern counters
  bp_ctr_table #(.IDX_W(GHR_W), .RST_VAL(CTR_WEAK_NT)) u_glb (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(ghr_q), .rd_a_val(glb_p),
    .rd_b_idx(res_ghr), .rd_b_val(glb_r),
    .wr_en(res_valid), .wr_idx(res_ghr), .wr_val(glb_w)
  );

  // chooser counters: high half favours the history table
  bp_ctr_table #(.IDX_W(GHR_W), .RST_VAL(CTR_WEAK_NT)) u_cho (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(ghr_q), .rd_a_val(cho_p),
    .rd_b_idx(res_ghr), .rd_b_val(cho_r),
    .wr_en(cho_we), .wr_idx(res_ghr), .wr_val(cho_w)
  );

  // prediction path
  assign pred_taken = cho_p[1] ? glb_p[1] : loc_p[1];
  assign pred_ghr   = ghr_q;

  // training path
  always_comb begin
    loc_dir_r = loc_r[1];
    glb_dir_r = glb_r[1];
    loc_w     = ctr_step(loc_r, res_taken);
    glb_w     = ctr_step(glb_r, res_taken);
    cho_we    = res_valid && (loc_dir_r != glb_dir_r);
    cho_w     = ctr_step(cho_r, glb_dir_r == res_taken);
  end

  assign mispred  = res_valid && (res_pred != res_taken);
  assign shift_en = pred_valid;

  bp_hist_reg #(.W(GHR_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .load_en(mispred), .load_val({res_ghr[GHR_W-2:0], res_taken}),
    .shift_en(shift_en), .shift_bit(pred_taken),
    .hist(ghr_q)
  );

  logic unused_bits;
  assign unused_bits = ^{pred_pc[PC_W-1:LOC_HI+1], pred_pc[LOC_LO-1:0],
                         res_pc[PC_W-1:LOC_HI+1], res_pc[LOC_LO-1:0],
                         loc_p[0], glb_p[0], cho_p[0]};

endmodule

// File: rtl/bp_tournament_chk.sv
module bp_tournament_chk #(
  parameter int PC_W  = 32,
  parameter int GHR_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pred_valid,
  input logic [PC_W-1:0]  pred_pc,
  input logic             pred_taken,
  input logic [GHR_W-1:0] pred_ghr,
  input logic             res_valid,
  input logic             res_taken,
  input logic             res_pred,
  input logic [GHR_W-1:0] res_ghr
);

  logic bad_res;
  assign bad_res = res_valid && (res_pred != res_taken);

  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && !bad_res) |=>
      pred_ghr == {$past(pred_ghr[GHR_W-2:0]), $past(pred_taken)});

  assert_hist_repair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_res |=> pred_ghr == {$past(res_ghr[GHR_W-2:0]), $past(res_taken)});

  assert_hist_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pred_valid && !bad_res) |=> $stable(pred_ghr));

  assert_pred_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(res_valid) && $stable(pred_pc) && $stable(pred_ghr)) |-> $stable(pred_taken));

endmodule

bind bp_tournament bp_tournament_chk #(.PC_W(PC_W), .GHR_W(GHR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc),
  .pred_taken(pred_taken), .pred_ghr(pred_ghr), .res_valid(res_valid),
  .res_taken(res_taken), .res_pred(res_pred), .res_ghr(res_ghr)
);

// File: tb/sim_bp_tournament.sv
`timescale 1ns/1ps
module sim_bp_tournament;

  localparam int PC_W = 32;
  localparam int GW   = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pred_valid = 1'b0;
  logic [31:0]   pred_pc = '0;
  logic          pred_taken;
  logic [GW-1:0] pred_ghr;
  logic          res_valid = 1'b0;
  logic [31:0]   res_pc = '0;
  logic          res_taken = 1'b0;
  logic          res_pred = 1'b0;
  logic [GW-1:0] res_ghr = '0;

  int   n_chk = 0;
  int   n_err = 0;
  logic done = 1'b0;
  logic          o_taken;
  logic [GW-1:0] o_ghr;

  always #4 clk = ~clk;

  bp_tournament #(.PC_W(PC_W), .LOC_IDX_W(10), .GHR_W(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_ghr(pred_ghr), .res_valid(res_valid),
    .res_pc(res_pc), .res_taken(res_taken), .res_pred(res_pred), .res_ghr(res_ghr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, sample outputs before the rising edge
  task automatic step(input logic pv, input logic [31:0] ppc, input logic rv,
                      input logic [31:0] rpc, input logic rt, input logic rp,
                      input logic [GW-1:0] rg);
    @(negedge clk);
    pred_valid = pv; pred_pc = ppc;
    res_valid = rv; res_pc = rpc; res_taken = rt; res_pred = rp; res_ghr = rg;
    #1;
    o_taken = pred_taken;
    o_ghr   = pred_ghr;
    @(posedge clk);
  endtask

  task automatic probe(input logic [31:0] pc);
    step(1'b0, pc, 1'b0, 32'h0, 1'b0, 1'b0, '0);
  endtask

  task automatic resolve(input logic [31:0] pc, input logic t, input logic p, input logic [GW-1:0] g);
    step(1'b0, 32'h0, 1'b1, pc, t, p, g);
  endtask

  task automatic t_reset;
    probe(32'h100);
    check("R1 reset prediction", o_taken, 0);
    check("R1 reset history", o_ghr, 0);
  endtask

  task automatic t_local;
    resolve(32'h100, 1, 1, 0);
    probe(32'h100);  check("R2 trained entry taken", o_taken, 1);
    probe(32'h104);  check("R2 neighbour untouched", o_taken, 0);
    probe(32'h1100); check("R2 alias shares entry", o_taken, 1);
    check("R9 history held", o_ghr, 0);
    for (int i = 0; i < 3; i++) resolve(32'h100, 1, 1, 0);
    resolve(32'h100, 0, 0, 0);
    probe(32'h100);  check("R4 saturated at 3", o_taken, 1);
    resolve(32'h100, 0, 0, 0);
    probe(32'h100);  check("R4 down to 1", o_taken, 0);
    resolve(32'h100, 0, 0, 0);
    resolve(32'h100, 0, 0, 0);
    resolve(32'h100, 1, 1, 0);
    probe(32'h100);  check("R4 saturated at 0", o_taken, 0);
  endtask

  task automatic t_chooser;
    resolve(32'h300, 1, 1, 10'h003);
    resolve(32'h304, 1, 1, 10'h003);
    resolve(32'h400, 1, 0, 10'h001);
    probe(32'h308);
    check("R7 repair load", o_ghr, 10'h003);
    check("R3 R5 chooser picks history table", o_taken, 1);
    resolve(32'h308, 0, 0, 10'h003);
    probe(32'h308);  check("R5 chooser back to local", o_taken, 0);
    resolve(32'h300, 0, 0, 10'h003);
    probe(32'h304);  check("R5 chooser unchanged on agreement", o_taken, 1);
  endtask

  task automatic t_history;
    step(1'b1, 32'h304, 1'b0, 32'h0, 1'b0, 1'b0, '0);
    check("R6 predict direction", o_taken, 1);
    check("R6 snapshot", o_ghr, 10'h003);
    step(1'b1, 32'h500, 1'b0, 32'h0, 1'b0, 1'b0, '0);
    check("R6 shift in taken", o_ghr, 10'h007);
    check("R6 second prediction", o_taken, 0);
    probe(32'h0);
    check("R6 shift in not-taken", o_ghr, 10'h00E);
    resolve(32'h600, 1, 0, 10'h3FF);
    step(1'b1, 32'h100, 1'b0, 32'h0, 1'b0, 1'b0, '0);
    check("R7 repair all ones", o_ghr, 10'h3FF);
    probe(32'h0);
    check("R6 top bit dropped", o_ghr, 10'h3FE);
  endtask

  task automatic t_priority;
    step(1'b1, 32'h100, 1'b1, 32'h900, 1'b0, 1'b1, 10'h005);
    step(1'b1, 32'h100, 1'b1, 32'h800, 1'b1, 1'b1, 10'h000);
    check("R7 repair beats predict", o_ghr, 10'h00A);
    check("R6 predict with correct resolve", o_taken, 0);
    probe(32'h0);
    check("R6 shift alongside correct resolve", o_ghr, 10'h014);
  endtask

  task automatic t_same_cycle;
    step(1'b1, 32'h700, 1'b1, 32'h700, 1'b1, 1'b1, 10'h000);
    check("R8 predict sees old value", o_taken, 0);
    probe(32'h700);
    check("R8 update visible next cycle", o_taken, 1);
    check("R6 history after same-cycle", o_ghr, 10'h028);
  endtask

  task automatic t_idle;
    for (int i = 0; i < 4; i++) probe(32'h0);
    probe(32'h700);
    check("R9 history stable when idle", o_ghr, 10'h028);
    check("R9 tables stable when idle", o_taken, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_local();
    t_chooser();
    t_history();
    t_priority();
    t_same_cycle();
    t_idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule